// File: doc/BRIEF.md
# Fixed-Point Word-Length Reducer

This block narrows a signed two's complement fixed-point sample by removing low-order fractional bits while leaving every integer bit in place. A per-sample selector picks between plain truncation, which drops the removed bits, and round-half-up, which adds the most significant removed bit (the guard bit) into the new least significant bit. A second per-sample selector decides what happens when rounding carries past the top of the narrower word: either the result is clamped to the largest positive value or it wraps modulo the output width. In both cases an overflow flag reports the event.

The narrowed word, its overflow flag and a valid flag are registered, so a result appears one clock after its input strobe. With the default parameters a 16-bit word with 8 fractional bits becomes a 12-bit word with 4 fractional bits. The number of dropped bits is the difference between the input and output widths.

Top module: `fxr_top`

## Requirements
- R1: With truncation selected (`rnd_sel`=0), `out_data` equals the input divided by 2^D and rounded toward minus infinity, where D = IN_W - OUT_W. This is the same as taking input bits [IN_W-1:D].
- R2: With rounding selected (`rnd_sel`=1), `out_data` equals the truncated value plus input bit D-1. The guard bit is either 0 or 1.
- R3: For the input 0x006B (0.01101011 with 8 fractional bits), the output is 0x006 (0.0110) under truncation and 0x007 (0.0111) under rounding.
- R4: Truncating a negative input moves it toward more negative values. For example, -17/256 (0xFFEF) truncates to 0xFFE, which is -2/16.
- R5: `out_ovf` is 1 exactly when the rounded value exceeds 2^(OUT_W-1)-1 or falls below -2^(OUT_W-1). Truncation never raises it, and neither does a negative input.
- R6: With saturation enabled (`sat_en`=1), an overflowing result is replaced by the signed extreme on its side. For the default widths the positive extreme is 0x7FF.
- R7: With saturation disabled, an overflowing result wraps modulo 2^OUT_W. For example, rounding 0x7FF8 gives 0x800.
- R8: `out_valid` follows `in_valid` delayed by one clock. `out_data` and `out_ovf` load only in a cycle where `in_valid` is 1, and otherwise hold their values.
- R9: While synchronous `rst` is 1, `out_valid`, `out_data` and `out_ovf` are cleared to 0 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input word, IN_FRAC fractional bits |
| rnd_sel | input | 1 | 0 truncate, 1 round-half-up |
| sat_en | input | 1 | 1 clamp on overflow, 0 wrap |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | OUT_W | Signed narrowed word |
| out_ovf | output | 1 | Rounding carried past the output range |

## Verification
The hardest condition to reach is the carry out of the top bit. It needs every kept bit to hold the largest positive pattern and the guard bit to be set at the same time, and uniformly drawn inputs hit that only about once in several thousand samples. The stimulus therefore steps directly through the inputs 0x7FF0 to 0x7FFF under every combination of mode and saturation, so that overflow, the clamp, the wrap and the inputs just below the threshold are all exercised. A behavioural model then checks a long random stream against the hold and latency behaviour.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    typedef enum logic {
        RQ_TRUNC = 1'b0,
        RQ_ROUND = 1'b1
    } rq_mode_e;

    typedef struct packed {
        rq_mode_e mode;
        logic     sat_en;
    } rq_ctrl_t;

    function automatic rq_ctrl_t make_ctrl(logic rnd, logic sat);
        rq_ctrl_t c;
        c.mode   = rnd ? RQ_ROUND : RQ_TRUNC;
        c.sat_en = sat;
        return c;
    endfunction

    function automatic logic guard_inc(rq_mode_e m, logic guard);
        return (m == RQ_ROUND) && guard;
    endfunction

endpackage

// File: rtl/fxr_quant.sv
module fxr_quant
    import fxr_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12
) (
    input  logic [IN_W-1:0]  in_word,
    input  rq_mode_e         mode,
    output logic [OUT_W:0]   ext_sum
);
    localparam int DROP = IN_W - OUT_W;

    generate
        if (DROP == 0) begin : g_pass
            logic unused_mode;
            assign unused_mode = mode;
            assign ext_sum = {in_word[IN_W-1], in_word};
        end else begin : g_cut
            logic [OUT_W-1:0] kept;
            logic             inc;
            logic             unused_low;
            assign kept       = in_word[IN_W-1:DROP];
            assign inc        = guard_inc(mode, in_word[DROP-1]);
            assign unused_low = ^in_word[DROP-1:0];
            assign ext_sum    = {kept[OUT_W-1], kept} + {{OUT_W{1'b0}}, inc};
        end
    endgenerate

endmodule

// File: rtl/fxr_limit.sv
module fxr_limit #(
    parameter int OUT_W = 12
) (
    input  logic [OUT_W:0]   ext_sum,
    input  logic             sat_en,
    output logic [OUT_W-1:0] res,
    output logic             ovf
);
    localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    always_comb begin
        ovf = ext_sum[OUT_W] ^ ext_sum[OUT_W-1];
        if (ovf && sat_en)
            res = ext_sum[OUT_W] ? NEG_MIN : POS_MAX;
        else
            res = ext_sum[OUT_W-1:0];
    end

endmodule

// File: rtl/fxr_stage.sv
module fxr_stage #(
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OUT_W-1:0] d_data,
    input  logic             d_ovf,
    output logic             q_valid,
    output logic [OUT_W-1:0] q_data,
    output logic             q_ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_data  <= '0;
            q_ovf   <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) begin
                q_data <= d_data;
                q_ovf  <= d_ovf;
            end
        end
    end

endmodule

// File: rtl/fxr_top.sv
module fxr_top
    import fxr_pkg::*;
#(
    parameter int IN_W    = 16,
    parameter int IN_FRAC = 8,
    parameter int OUT_W   = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic             rnd_sel,
    input  logic             sat_en,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             out_ovf
);
    localparam int DROP = IN_W - OUT_W;

    generate
        if (DROP < 0 || DROP > IN_FRAC) begin : g_bad_widths
            $error("fxr_top: output width must keep all integer bits");
        end
    endgenerate

    rq_ctrl_t         ctrl;
    logic [OUT_W:0]   ext_sum;
    logic [OUT_W-1:0] lim_res;
    logic             lim_ovf;

    assign ctrl = make_ctrl(rnd_sel, sat_en);

    fxr_quant #(.IN_W(IN_W), .OUT_W(OUT_W)) u_quant (
        .in_word (in_data),
        .mode    (ctrl.mode),
        .ext_sum (ext_sum)
    );

    fxr_limit #(.OUT_W(OUT_W)) u_limit (
        .ext_sum (ext_sum),
        .sat_en  (ctrl.sat_en),
        .res     (lim_res),
        .ovf     (lim_ovf)
    );

    fxr_stage #(.OUT_W(OUT_W)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .d_data  (lim_res),
        .d_ovf   (lim_ovf),
        .q_valid (out_valid),
        .q_data  (out_data),
        .q_ovf   (out_ovf)
    );

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid) else $error("valid not delayed"); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_ovf))) else $error("idle output moved"); // R8
    AST_TRUNC_NO_OVF: assert property (@(posedge clk) disable iff (rst) (in_valid && !rnd_sel) |=> !out_ovf) else $error("overflow on truncation"); // R5
    AST_NEG_NO_OVF: assert property (@(posedge clk) disable iff (rst) (in_valid && in_data[IN_W-1]) |=> !out_ovf) else $error("overflow on negative input"); // R5
    AST_SAT_SIGN: assert property (@(posedge clk) disable iff (rst) (in_valid && sat_en && !in_data[IN_W-1]) |=> !out_data[OUT_W-1]) else $error("saturated result changed sign"); // R6

endmodule

// File: tb/sim_fxr_top.sv
`timescale 1ns/1ps
module sim_fxr_top;
    localparam int IN_W  = 16;
    localparam int IN_FR = 8;
    localparam int OUT_W = 12;
    localparam int D     = IN_W - OUT_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic             rnd_sel = 1'b0;
    logic             sat_en = 1'b0;
    logic             out_valid;
    logic [OUT_W-1:0] out_data;
    logic             out_ovf;

    int errors = 0;
    int checks = 0;

    logic             m_valid = 1'b0;
    logic [OUT_W-1:0] m_data  = '0;
    logic             m_ovf   = 1'b0;

    always #4 clk = ~clk;

    fxr_top #(.IN_W(IN_W), .IN_FRAC(IN_FR), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .rnd_sel(rnd_sel), .sat_en(sat_en), .out_valid(out_valid),
        .out_data(out_data), .out_ovf(out_ovf)
    );

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic model(input logic [IN_W-1:0] v, input logic rnd, input logic sat,
                         output logic [OUT_W-1:0] d, output logic o);
        int s, t, r, mx, mn;
        s  = int'($signed(v));
        t  = s >>> D;
        r  = t + (rnd ? ((s >>> (D - 1)) & 1) : 0);
        mx = (1 << (OUT_W - 1)) - 1;
        mn = -(1 << (OUT_W - 1));
        o  = (r > mx) || (r < mn);
        if (o && sat) r = (r > mx) ? mx : mn;
        d  = r[OUT_W-1:0];
    endtask

    task automatic cyc(string tag, input logic vld, input logic [IN_W-1:0] v,
                       input logic rnd, input logic sat);
        logic [OUT_W-1:0] d;
        logic o;
        in_valid = vld; in_data = v; rnd_sel = rnd; sat_en = sat;
        @(posedge clk);
        #2;
        if (rst) begin
            m_valid = 1'b0; m_data = '0; m_ovf = 1'b0;
        end else begin
            m_valid = vld;
            if (vld) begin
                model(v, rnd, sat, d, o);
                m_data = d; m_ovf = o;
            end
        end
        check({tag, " valid"}, int'(out_valid), int'(m_valid));
        check({tag, " data"},  int'(out_data),  int'(m_data));
        check({tag, " ovf"},   int'(out_ovf),   int'(m_ovf));
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        cyc("R9 reset", 1'b1, 16'h7FF8, 1'b1, 1'b0);
        cyc("R9 reset", 1'b0, 16'h0000, 1'b0, 1'b0);
        check("R9 reset data", int'(out_data), 0);
        rst = 1'b0;

        cyc("R3 trunc", 1'b1, 16'h006B, 1'b0, 1'b0);
        check("R3 trunc lit", int'(out_data), 12'h006);
        cyc("R3 round", 1'b1, 16'h006B, 1'b1, 1'b0);
        check("R3 round lit", int'(out_data), 12'h007);

        cyc("R1 trunc", 1'b1, 16'h1234, 1'b0, 1'b1);
        cyc("R1 trunc", 1'b1, 16'h4FFF, 1'b0, 1'b0);
        cyc("R2 round", 1'b1, 16'h1238, 1'b1, 1'b1);
        cyc("R2 round", 1'b1, 16'h1237, 1'b1, 1'b0);

        cyc("R4 neg trunc", 1'b1, 16'hFFEF, 1'b0, 1'b0);
        check("R4 neg lit", int'(out_data), 12'hFFE);
        cyc("R4 neg round", 1'b1, 16'hFFEF, 1'b1, 1'b0);
        cyc("R4 min trunc", 1'b1, 16'h8000, 1'b0, 1'b1);
        cyc("R4 min round", 1'b1, 16'h8008, 1'b1, 1'b1);

        for (int v = 16'h7FF0; v <= 16'h7FFF; v++) begin
            for (int m = 0; m < 4; m++) begin
                cyc("R5 R6 R7 edge", 1'b1, v[IN_W-1:0], m[0], m[1]);
            end
        end
        cyc("R6 sat", 1'b1, 16'h7FF8, 1'b1, 1'b1);
        check("R6 sat lit", int'(out_data), 12'h7FF);
        check("R5 ovf lit", int'(out_ovf), 1);
        cyc("R7 wrap", 1'b1, 16'h7FF8, 1'b1, 1'b0);
        check("R7 wrap lit", int'(out_data), 12'h800);

        cyc("R8 load", 1'b1, 16'h0ABC, 1'b1, 1'b0);
        cyc("R8 hold", 1'b0, 16'h7FF8, 1'b1, 1'b0);
        check("R8 hold lit", int'(out_data), 12'h0AC);
        cyc("R8 hold", 1'b0, 16'h8001, 1'b0, 1'b1);

        for (int i = 0; i < 400; i++) begin
            cyc("R1 R2 R8 random", 1'($urandom_range(0, 3) != 0),
                16'($urandom), 1'($urandom), 1'($urandom));
        end

        rst = 1'b1;
        cyc("R9 mid reset", 1'b1, 16'h7FF8, 1'b1, 1'b0);
        rst = 1'b0;
        cyc("R9 after reset", 1'b0, 16'h0000, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule